// File: doc/BRIEF.md
# Multi-Format Stereo Audio Serial Receiver

This block turns a stereo serial audio stream into parallel samples. The stream has a bit clock, a channel-select clock and a serial data line. The block runs directly on the bit clock and samples both the channel clock and the data on every rising edge. It finds the boundaries between channel halves from changes of the channel clock. From each half it takes the data word in one of four framings, picked by a two-bit format input. It then emits a left and right pair of 24-bit two's-complement samples together with a one-cycle valid pulse.

Two serial data lines can feed the block. The second line is used only when the control side runs in its three-wire mode and the select bit is set. Each channel has its own invert input. This input negates that channel's sample, and the one value that cannot be negated saturates to the largest positive code. Sixteen-bit words are left-aligned into the 24-bit sample, and the low byte is filled with zeros.

The host holds the format and option inputs steady while a stream runs. After any change of format it applies reset. The register that drives the format input is expected to come out of reset at 2'b11.

Top module: `sarx_top`

## Requirements
- R1: While reset is low, `left_o` and `right_o` are zero and `valid_o` is low. The first channel-clock change after reset only marks a boundary: the half that ends there is discarded.
- R2: Data is sampled on the rising bit-clock edge, MSB first. `valid_o` goes high for exactly one cycle, in the cycle after the rising edge that sees the channel-clock change ending a right half. Both outputs change in that cycle only.
- R3: Format 2'b00 takes the last 16 bits before the channel-clock change as the word and places them in bits [23:8] with [7:0] zero. Earlier bits of the half are ignored. This works with 16 bits per half and with longer halves.
- R4: Format 2'b01 takes the last 24 bits before the channel-clock change as the word. Earlier bits of the half are ignored.
- R5: Format 2'b10 takes the first 24 bits of the half, starting with the bit sampled at the edge that sees the change. Later bits are ignored.
- R6: In format 2'b11 the bit sampled at the change edge still belongs to the previous word. If a half holds at least 25 bits, the word is the 24 bits that follow that bit. If a half holds 16 bits, the 16-bit word, whose LSB spills into the next half, is left-aligned into 24 bits.
- R7: In formats 2'b00, 2'b01 and 2'b10 a high channel clock carries the left channel. In format 2'b11 a low channel clock carries the left channel.
- R8: `sd_b_i` is used only when `three_wire_i` and `sel_b_i` are both 1. In all other cases `sd_a_i` is used and `sd_b_i` has no effect.
- R9: `inv_l_i` and `inv_r_i` each negate their own channel's output sample. 24'h800000 inverts to 24'h7FFFFF.
- R10: A pair is emitted only after a left half and then a right half, both ending after the first boundary. There is at most one pulse per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bick_i | input | 1 | Serial bit clock; all state changes on its rising edge |
| rst_ni | input | 1 | Active-low reset |
| lrck_i | input | 1 | Channel-select clock |
| sd_a_i | input | 1 | Primary serial data line |
| sd_b_i | input | 1 | Secondary serial data line |
| fmt_i | input | 2 | Framing: 00 LSB16, 01 LSB24, 10 MSB24, 11 I2S |
| three_wire_i | input | 1 | Control side is in three-wire mode |
| sel_b_i | input | 1 | Use the secondary line (three-wire mode only) |
| inv_l_i | input | 1 | Negate left output |
| inv_r_i | input | 1 | Negate right output |
| left_o | output | 24 | Left sample, two's complement |
| right_o | output | 24 | Right sample, two's complement |
| valid_o | output | 1 | One-cycle pulse when a new pair is presented |

## Verification
The hardest case to reach from the ports is the I2S framing at 16 bits per half. There the last bit of each word arrives after the channel clock has already switched, so the word is only complete on the boundary edge itself. The bench makes this case by building each half as an MSB-first word and then delaying the whole data stream by one bit clock against the channel clock. This forces the LSB of the right word into the first slot of the following half. A trailing partial half after the last frame commits the final pair. Random filler bits in the unused slots, and the complemented stream on the unused data line, show that ignored bits and the unselected input do not reach the outputs.

// File: rtl/sarx_pkg.sv
package sarx_pkg;
   typedef enum logic [1:0] {
      FMT_LSB16 = 2'b00,
      FMT_LSB24 = 2'b01,
      FMT_MSB24 = 2'b10,
      FMT_I2S   = 2'b11
   } sarx_fmt_e;

   function automatic logic left_level(input sarx_fmt_e f);
      return (f == FMT_I2S) ? 1'b0 : 1'b1;
   endfunction
endpackage

// File: rtl/sarx_front.sv
module sarx_front #(
   parameter int W     = 24,
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lrck,
   input  logic             sd,
   input  logic             skip,
   output logic             edge_o,
   output logic             lvl_o,
   output logic             seen_o,
   output logic [W-1:0]     tail_o,
   output logic [W-1:0]     join_o,
   output logic [W-1:0]     early_o,
   output logic [CNT_W-1:0] len_o
);
   localparam int CNT_MAX = (1 << CNT_W) - 1;

   if ((1 << CNT_W) <= W + 1) begin : g_bad_cnt
      $error("sarx_front: CNT_W too small for word width");
   end

   logic             armed_q, lrck_q, seen_q;
   logic [CNT_W-1:0] pos_q, pos_nx;
   logic [W-1:0]     sr_q, early_q, join_w;

   assign edge_o  = armed_q && (lrck != lrck_q);
   assign join_w  = {sr_q[W-2:0], sd};
   assign lvl_o   = lrck_q;
   assign seen_o  = seen_q;
   assign tail_o  = sr_q;
   assign join_o  = join_w;
   assign early_o = early_q;
   assign len_o   = pos_q;

   always_comb begin
      if (edge_o)
         pos_nx = '0;
      else if (pos_q == CNT_W'(CNT_MAX))
         pos_nx = pos_q;
      else
         pos_nx = pos_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         lrck_q  <= 1'b0;
         seen_q  <= 1'b0;
         pos_q   <= '0;
         sr_q    <= '0;
         early_q <= '0;
      end else begin
         armed_q <= 1'b1;
         lrck_q  <= lrck;
         pos_q   <= pos_nx;
         sr_q    <= join_w;
         if (int'(pos_nx) == W - 1 + int'(skip))
            early_q <= join_w;
         if (edge_o)
            seen_q <= 1'b1;
      end
   end

   // R2: a boundary is only reported when the channel clock really moved
   p_edge_change_r2: assert property (@(posedge clk) disable iff (!rst_n)
      edge_o |-> (lrck != $past(lrck)));
endmodule

// File: rtl/sarx_pick.sv
module sarx_pick #(
   parameter int W     = 24,
   parameter int SW    = 16,
   parameter int CNT_W = 6
) (
   input  sarx_pkg::sarx_fmt_e fmt,
   input  logic [W-1:0]        tail,
   input  logic [W-1:0]        joined,
   input  logic [W-1:0]        early,
   input  logic [CNT_W-1:0]    len,
   output logic [W-1:0]        word
);
   import sarx_pkg::*;

   if (SW > W || SW < 2) begin : g_bad_sw
      $error("sarx_pick: short word width out of range");
   end

   logic [W-1:0] short_w;

   if (W > SW) begin : g_pad
      assign short_w = {tail[SW-1:0], {(W-SW){1'b0}}};
   end else begin : g_full
      assign short_w = tail;
   end

   always_comb begin
      word = '0;
      unique case (fmt)
         FMT_LSB16: word = short_w;
         FMT_LSB24: word = tail;
         FMT_MSB24: word = early;
         FMT_I2S: begin
            if (int'(len) >= W)
               word = early;
            else
               word = joined << (W - 1 - int'(len));
         end
         default: word = '0;
      endcase
   end
endmodule

// File: rtl/sarx_polarity.sv
module sarx_polarity #(
   parameter int W = 24
) (
   input  logic [W-1:0] din_i,
   input  logic         inv_i,
   output logic [W-1:0] dout_o
);
   localparam logic [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};
   localparam logic [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};

   always_comb begin
      if (!inv_i)
         dout_o = din_i;
      else if (din_i == MIN_V)
         dout_o = MAX_V;
      else
         dout_o = -din_i;
   end

   // R9: an inverted output never lands on the most negative code
   always_comb begin
      if (inv_i === 1'b1 && !$isunknown(din_i))
         a_no_min_r9: assert (dout_o != MIN_V);
   end
endmodule

// File: rtl/sarx_top.sv
module sarx_top #(
   parameter int SAMPLE_W = 24,
   parameter int SHORT_W  = 16,
   parameter int CNT_W    = 6
) (
   input  logic                bick_i,
   input  logic                rst_ni,
   input  logic                lrck_i,
   input  logic                sd_a_i,
   input  logic                sd_b_i,
   input  logic [1:0]          fmt_i,
   input  logic                three_wire_i,
   input  logic                sel_b_i,
   input  logic                inv_l_i,
   input  logic                inv_r_i,
   output logic [SAMPLE_W-1:0] left_o,
   output logic [SAMPLE_W-1:0] right_o,
   output logic                valid_o
);
   import sarx_pkg::*;

   localparam int NCH = 2;

   if (SAMPLE_W < 8) begin : g_bad_w
      $error("sarx_top: SAMPLE_W too small");
   end

   sarx_fmt_e     fmt_w;
   logic          sd_w, skip_w;
   logic          edge_w, lvl_w, seen_w, is_left_w;
   logic [SAMPLE_W-1:0] tail_w, join_w, early_w, word_w;
   logic [CNT_W-1:0]    len_w;
   logic [SAMPLE_W-1:0] l_pend_q;
   logic                l_have_q;
   logic [SAMPLE_W-1:0] pol_in  [NCH];
   logic [SAMPLE_W-1:0] pol_out [NCH];
   logic                pol_inv [NCH];

   assign fmt_w     = sarx_fmt_e'(fmt_i);
   assign sd_w      = (three_wire_i && sel_b_i) ? sd_b_i : sd_a_i;
   assign skip_w    = (fmt_w == FMT_I2S);
   assign is_left_w = (lvl_w == left_level(fmt_w));

   sarx_front #(.W(SAMPLE_W), .CNT_W(CNT_W)) front_i (
      .clk     (bick_i),
      .rst_n   (rst_ni),
      .lrck    (lrck_i),
      .sd      (sd_w),
      .skip    (skip_w),
      .edge_o  (edge_w),
      .lvl_o   (lvl_w),
      .seen_o  (seen_w),
      .tail_o  (tail_w),
      .join_o  (join_w),
      .early_o (early_w),
      .len_o   (len_w)
   );

   sarx_pick #(.W(SAMPLE_W), .SW(SHORT_W), .CNT_W(CNT_W)) pick_i (
      .fmt    (fmt_w),
      .tail   (tail_w),
      .joined (join_w),
      .early  (early_w),
      .len    (len_w),
      .word   (word_w)
   );

   assign pol_in[0]  = l_pend_q;
   assign pol_in[1]  = word_w;
   assign pol_inv[0] = inv_l_i;
   assign pol_inv[1] = inv_r_i;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      sarx_polarity #(.W(SAMPLE_W)) pol_i (
         .din_i  (pol_in[c]),
         .inv_i  (pol_inv[c]),
         .dout_o (pol_out[c])
      );
   end

   always_ff @(posedge bick_i or negedge rst_ni) begin
      if (!rst_ni) begin
         l_pend_q <= '0;
         l_have_q <= 1'b0;
         left_o   <= '0;
         right_o  <= '0;
         valid_o  <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (edge_w && seen_w) begin
            if (is_left_w) begin
               l_pend_q <= word_w;
               l_have_q <= 1'b1;
            end else begin
               if (l_have_q) begin
                  left_o  <= pol_out[0];
                  right_o <= pol_out[1];
                  valid_o <= 1'b1;
               end
               l_have_q <= 1'b0;
            end
         end
      end
   end

   // R2: single-cycle pulse
   p_pulse_r2: assert property (@(posedge bick_i) disable iff (!rst_ni)
      valid_o |=> !valid_o);
   // R2: samples only move together with the pulse
   p_hold_r2: assert property (@(posedge bick_i) disable iff (!rst_ni)
      !valid_o |-> ($stable(left_o) && $stable(right_o)));
   // R10: a pulse follows a boundary seen after the first one
   p_from_edge_r10: assert property (@(posedge bick_i) disable iff (!rst_ni)
      valid_o |-> $past(edge_w && seen_w));
   // R10: a left word was held before the pair went out
   p_left_first_r10: assert property (@(posedge bick_i) disable iff (!rst_ni)
      valid_o |-> $past(l_have_q));
endmodule

// File: tb/sarx_top_tb_top.sv
module sarx_top_tb_top;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n = 1'b0, lrck = 1'b0, sd_a = 1'b0, sd_b = 1'b0;
   logic [1:0] fmt = 2'b11;
   logic tw = 1'b0, selb = 1'b0, invl = 1'b0, invr = 1'b0;
   logic [23:0] left_w, right_w;
   logic valid_w;

   sarx_top dut_i (
      .bick_i(clk), .rst_ni(rst_n), .lrck_i(lrck), .sd_a_i(sd_a), .sd_b_i(sd_b),
      .fmt_i(fmt), .three_wire_i(tw), .sel_b_i(selb), .inv_l_i(invl), .inv_r_i(invr),
      .left_o(left_w), .right_o(right_w), .valid_o(valid_w)
   );

   int checks = 0, errors = 0, cyc = 0;
   bit mon_en = 1'b0, i2s_prev = 1'b0, ev = 1'b0;
   int q_cyc[$];
   logic [23:0] q_l[$];
   logic [23:0] q_r[$];
   string cur_tag = "R2";

   function automatic logic [23:0] neg24(input logic [23:0] x);
      if (x == 24'h800000) return 24'h7FFFFF;
      return -x;
   endfunction

   task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // reference comparison on every clock
   always @(posedge clk) begin
      cyc++;
      #2;
      if (mon_en) begin
         while (q_cyc.size() > 0 && q_cyc[0] < cyc) begin
            checks++; errors++;
            $display("FAIL R10 missed pair actual=none expected=cycle %0d", q_cyc[0]);
            void'(q_cyc.pop_front()); void'(q_l.pop_front()); void'(q_r.pop_front());
         end
         ev = (q_cyc.size() > 0 && q_cyc[0] == cyc);
         check("R2/R10 valid", {23'd0, valid_w}, {23'd0, ev});
         if (ev) begin
            check({cur_tag, " left"}, left_w, q_l[0]);
            check({cur_tag, " right"}, right_w, q_r[0]);
            void'(q_cyc.pop_front()); void'(q_l.pop_front()); void'(q_r.pop_front());
         end
      end
   end

   task automatic send_half(input bit lvl, input logic [23:0] w, input int h, input bit junk_only,
                            input bit push, input logic [23:0] pl, input logic [23:0] pr);
      for (int j = 0; j < h; j++) begin
         bit b, d;
         int wd;
         b = 1'($urandom_range(0, 1));
         wd = (h >= 25) ? 24 : 16;
         if (!junk_only) begin
            case (fmt)
               2'b00: if (j >= h - 16) b = w[23 - (j - (h - 16))];
               2'b01: if (j >= h - 24) b = w[23 - (j - (h - 24))];
               2'b10: if (j < 24) b = w[23 - j];
               default: if (j < wd) b = w[23 - j];
            endcase
         end
         if (fmt == 2'b11) begin
            d = i2s_prev;
            i2s_prev = b;
         end else begin
            d = b;
         end
         @(negedge clk);
         lrck = lvl;
         if (tw && selb) begin sd_b = d; sd_a = ~d; end
         else begin sd_a = d; sd_b = ~d; end
         if (j == 0 && push) begin
            q_cyc.push_back(cyc + 1);
            q_l.push_back(invl ? neg24(pl) : pl);
            q_r.push_back(invr ? neg24(pr) : pr);
         end
      end
   endtask

   task automatic run_case(input string tag, input logic [1:0] f, input int h, input bit t,
                           input bit s, input bit il, input bit ir, input int nfr);
      bit lv, short_fmt, have;
      logic [23:0] pl, pr, l, r, mask;
      cur_tag = tag;
      mon_en = 1'b0;
      @(negedge clk);
      rst_n = 1'b0;
      fmt = f; tw = t; selb = s; invl = il; invr = ir;
      lv = (f == 2'b11) ? 1'b0 : 1'b1;
      lrck = ~lv;
      i2s_prev = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 reset left", left_w, 24'h0);
      check("R1 reset right", right_w, 24'h0);
      check("R1 reset valid", {23'd0, valid_w}, 24'h0);
      rst_n = 1'b1;
      mon_en = 1'b1;
      short_fmt = (f == 2'b00) || (f == 2'b11 && h < 25);
      mask = short_fmt ? 24'hFFFF00 : 24'hFFFFFF;
      send_half(~lv, 24'h0, 5, 1'b1, 1'b0, 24'h0, 24'h0);
      have = 1'b0; pl = '0; pr = '0;
      for (int k = 0; k < nfr; k++) begin
         if (k == 0) begin
            l = 24'h800000;
            r = 24'h7FFFFF & mask;
         end else begin
            l = 24'($urandom()) & mask;
            r = 24'($urandom()) & mask;
         end
         send_half(lv, l, h, 1'b0, have, pl, pr);
         send_half(~lv, r, h, 1'b0, 1'b0, 24'h0, 24'h0);
         pl = l; pr = r; have = 1'b1;
      end
      send_half(lv, 24'h0, 4, 1'b1, 1'b1, pl, pr);
      repeat (4) @(negedge clk);
      check("R10 pending pairs", 24'(q_cyc.size()), 24'h0);
   endtask

   initial begin
      repeat (2) @(negedge clk);
      run_case("R4 R7 R8 lsb24", 2'b01, 32, 1'b0, 1'b1, 1'b0, 1'b0, 5);
      run_case("R3 R9 lsb16 32fs", 2'b00, 16, 1'b0, 1'b0, 1'b1, 1'b0, 5);
      run_case("R3 lsb16 64fs", 2'b00, 32, 1'b1, 1'b0, 1'b0, 1'b0, 4);
      run_case("R5 R9 msb24", 2'b10, 32, 1'b0, 1'b0, 1'b0, 1'b1, 5);
      run_case("R6 R8 i2s24", 2'b11, 32, 1'b1, 1'b1, 1'b0, 1'b0, 5);
      run_case("R6 R7 i2s16", 2'b11, 16, 1'b1, 1'b0, 1'b1, 1'b1, 5);
      run_case("R4 lsb24 48fs", 2'b01, 24, 1'b0, 1'b0, 1'b1, 1'b1, 4);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 150000);
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule